// File: doc/BRIEF.md
# Codec Control Register Bank with Two-Wire Target

This block is the control plane of a voice codec. A host reaches it over a standard I2C bus, as a target at a fixed 7-bit address. Behind the bus engine sit seven 8-bit control registers: power, mode, transmit gain with sidetone gain, receive gain with volume, tone routing, tone selection and auxiliary. Decoded control fields go straight to the analog and digital datapaths. The bus lines are oversampled by the system clock. The data line is open-drain: the block only ever pulls it low, through an output enable.

A host writes by sending the target address with the write bit, then a register index, then one or more data bytes. The index advances after each byte. To read, the host sets the index the same way, issues a repeated START and the target address with the read bit, then clocks bytes out. The index advances on every master ACK.

A strap pin sets the reset value of the power register. With the strap high, the codec runs with default gains and needs no host. With the strap low, it stays powered down until a host writes the power register.

Top module: `codec_ctrl_regbank`

## Requirements
- R1: A byte whose upper seven bits equal the target address is ACKed. Any other address byte is NACKed, and the bytes that follow it up to the next START are ignored and change no register. The data line is pulled low only by asserting `sda_oe`, and `sda_oe` is switched on only while SCL is low.
- R2: In a write, the register-index byte and each data byte are ACKed. The data byte is stored in the indexed register, and a later read of that index returns the stored byte.
- R3: The index advances by one after each written data byte and after each read byte that the master ACKs, so a burst covers consecutive registers. Reading an index of 7 or above returns 8'h00.
- R4: A register-index byte of 7 or above is NACKed. The data bytes after it change no register.
- R5: Reset (active-low `rst_n`) loads these defaults. Index 1 (mode) = 8'h00. Index 2 (transmit gain code in [3:0], sidetone gain code in [7:4], where code 0 means 0 dB transmit and -12 dB sidetone) = 8'h00. Index 3 (volume code in [3:0], where code 0 is 0 dB and each step is -2 dB; tone-path gain code in [6:4], where code 2 is 0 dB) = 8'h20. Indices 4, 5 and 6 = 8'h00.
- R6: The reset value of index 0 (power) is 8'h01 when `pwrup_strap` is high and 8'h00 when it is low. `pwr_down` is therefore 0 or 1 respectively after reset.
- R7: `pwr_down` is the inverse of power bit 0. `sidetone_en` is power bit 3 AND power bit 0, so sidetone is off whenever the codec is powered down.
- R8: `comp_mode` follows mode bits [1:0], where 00 means linear, 01 means mu-law and 10 means A-law. The unused code 11 decodes as 00. `tx_hpf_bypass`, `rx_hpf_bypass` and `loopback_en` follow mode bits 2, 3 and 4.
- R9: `tone_res` follows auxiliary (index 6) bits [1:0], where 00, 01 and 10 select the three step sizes. The unused code 11 decodes as 00.
- R10: In a write burst, a data byte that arrives when the index has already passed 6 is NACKed and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrup_strap | input | 1 | Power-up select: 1 = run with defaults, 0 = stay powered down |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| pwr_down | output | 1 | Codec power-down request |
| sidetone_en | output | 1 | Sidetone path enable |
| comp_mode | output | 2 | Sample format: 00 linear, 01 mu-law, 10 A-law |
| tx_hpf_bypass | output | 1 | Bypass the transmit high-pass filter |
| rx_hpf_bypass | output | 1 | Bypass the receive high-pass filter |
| loopback_en | output | 1 | Digital loopback enable |
| tone_res | output | 2 | Tone generator step-size select |

## Verification
A table of single-register writes steps the mode, power and auxiliary registers through every code, including the two unused codes. Each write is followed by a readback and a look at all decoded outputs. This separates a storage fault from a decode fault and shows whether the power gating of sidetone works. Bursts show whether the index advances and where it stops: a read that runs past the last register, and a write that overruns it. A wrong target address and out-of-range indices are then sent, and a full readback afterwards tells a silent ignore apart from a stray write. Two resets, one with the strap high and one with it low, separate the strap-driven power default from the fixed defaults.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   localparam int unsigned REG_W    = 8;
   localparam int unsigned NUM_REGS = 7;
   localparam int unsigned IDX_W    = 8;

   // register indices
   localparam int unsigned IX_PWR  = 0;
   localparam int unsigned IX_MODE = 1;
   localparam int unsigned IX_TXG  = 2;
   localparam int unsigned IX_RXG  = 3;
   localparam int unsigned IX_TRT  = 4;
   localparam int unsigned IX_TSEL = 5;
   localparam int unsigned IX_AUX  = 6;

   // field positions
   localparam int unsigned PWR_RUN_B  = 0;
   localparam int unsigned PWR_SIDE_B = 3;
   localparam int unsigned MODE_TXB_B = 2;
   localparam int unsigned MODE_RXB_B = 3;
   localparam int unsigned MODE_LPB_B = 4;

   typedef enum logic [3:0] {
      BS_IDLE,
      BS_ADDR,
      BS_ADDR_ACK,
      BS_INDEX,
      BS_INDEX_ACK,
      BS_WDATA,
      BS_WDATA_ACK,
      BS_RDATA,
      BS_RDATA_ACK
   } bus_state_t;

   function automatic logic [REG_W-1:0] reg_default(input int unsigned idx,
                                                     input logic strap);
      logic [REG_W-1:0] v;
      case (idx)
         IX_PWR:  v = {7'b0, strap};
         IX_RXG:  v = 8'h20;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ccr_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ccr_bus_target.sv
module ccr_bus_target
   import ccr_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h4A,
   parameter int unsigned NREGS    = NUM_REGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic [REG_W-1:0] rd_data,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [REG_W-1:0] wr_data,
   output logic [IDX_W-1:0] ptr
);

   localparam logic [IDX_W-1:0] LAST_OK = IDX_W'(NREGS);

   bus_state_t       state;
   logic             scl_q, sda_q;
   logic [2:0]       bit_cnt;
   logic [7:0]       rx_sh, tx_sh;
   logic             got_byte, rw_q, mst_ack;

   logic scl_rise, scl_fall, start_c, stop_c;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= BS_IDLE;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         got_byte <= 1'b0;
         rw_q     <= 1'b0;
         mst_ack  <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
         ptr      <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         wr_en <= 1'b0;
         if (stop_c) begin
            state  <= BS_IDLE;
            sda_oe <= 1'b0;
         end else if (start_c) begin
            state    <= BS_ADDR;
            bit_cnt  <= '0;
            got_byte <= 1'b0;
            sda_oe   <= 1'b0;
         end else begin
            case (state)
               BS_ADDR, BS_INDEX, BS_WDATA: begin
                  if (scl_rise && !got_byte) begin
                     rx_sh   <= {rx_sh[6:0], sda_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) got_byte <= 1'b1;
                  end else if (scl_fall && got_byte) begin
                     got_byte <= 1'b0;
                     bit_cnt  <= '0;
                     if (state == BS_ADDR) begin
                        if (rx_sh[7:1] == DEV_ADDR) begin
                           rw_q   <= rx_sh[0];
                           sda_oe <= 1'b1;
                           state  <= BS_ADDR_ACK;
                        end else begin
                           state <= BS_IDLE;
                        end
                     end else if (state == BS_INDEX) begin
                        ptr <= rx_sh;
                        if (rx_sh < LAST_OK) begin
                           sda_oe <= 1'b1;
                           state  <= BS_INDEX_ACK;
                        end else begin
                           state <= BS_IDLE;
                        end
                     end else begin
                        if (ptr < LAST_OK) begin
                           wr_en   <= 1'b1;
                           wr_data <= rx_sh;
                           sda_oe  <= 1'b1;
                           state   <= BS_WDATA_ACK;
                        end else begin
                           state <= BS_IDLE;
                        end
                     end
                  end
               end
               BS_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        tx_sh   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        bit_cnt <= '0;
                        state   <= BS_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= BS_INDEX;
                     end
                  end
               end
               BS_INDEX_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= BS_WDATA;
                  end
               end
               BS_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 1'b1;
                     state  <= BS_WDATA;
                  end
               end
               BS_RDATA: begin
                  if (scl_fall) begin
                     if (bit_cnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        state  <= BS_RDATA_ACK;
                     end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        sda_oe  <= ~tx_sh[6];
                     end
                  end
               end
               BS_RDATA_ACK: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_s;
                     if (!sda_s) ptr <= ptr + 1'b1;
                  end else if (scl_fall) begin
                     if (mst_ack) begin
                        tx_sh   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        bit_cnt <= '0;
                        state   <= BS_RDATA;
                     end else begin
                        state <= BS_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1
   oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R2
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
   import ccr_pkg::*;
#(
   parameter int unsigned NREGS = NUM_REGS,
   parameter int unsigned W     = REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strap,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [W-1:0]       wr_data,
   output logic [W-1:0]       rd_data,
   output logic [NREGS*W-1:0] regs_flat
);

   generate
      if (NREGS != NUM_REGS || W != REG_W) begin : g_bad_shape
         $error("ccr_regfile shape must match the package");
      end
   endgenerate

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= reg_default(g, strap);
         else if (wr_en && idx == IDX_W'(g))  q <= wr_data;
      end
      assign regs_flat[g*W +: W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (idx == IDX_W'(i)) rd_data = regs_flat[i*W +: W];
      end
   end

   // R4
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (idx < IDX_W'(NREGS)));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/ccr_field_decode.sv
module ccr_field_decode
   import ccr_pkg::*;
#(
   parameter int unsigned NREGS = NUM_REGS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREGS*REG_W-1:0] regs_flat,
   output logic                   pwr_down,
   output logic                   sidetone_en,
   output logic [1:0]             comp_mode,
   output logic                   tx_hpf_bypass,
   output logic                   rx_hpf_bypass,
   output logic                   loopback_en,
   output logic [1:0]             tone_res
);

   logic [REG_W-1:0] pwr_r, mode_r, aux_r;
   assign pwr_r  = regs_flat[IX_PWR*REG_W  +: REG_W];
   assign mode_r = regs_flat[IX_MODE*REG_W +: REG_W];
   assign aux_r  = regs_flat[IX_AUX*REG_W  +: REG_W];

   assign pwr_down      = ~pwr_r[PWR_RUN_B];
   assign sidetone_en   = pwr_r[PWR_SIDE_B] & pwr_r[PWR_RUN_B];
   assign comp_mode     = (mode_r[1:0] == 2'b11) ? 2'b00 : mode_r[1:0];
   assign tx_hpf_bypass = mode_r[MODE_TXB_B];
   assign rx_hpf_bypass = mode_r[MODE_RXB_B];
   assign loopback_en   = mode_r[MODE_LPB_B];
   assign tone_res      = (aux_r[1:0] == 2'b11) ? 2'b00 : aux_r[1:0];

   // R7
   side_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sidetone_en |-> !pwr_down);

   // R8
   comp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comp_mode != 2'b11);

   // R9
   tone_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tone_res != 2'b11);

endmodule

// File: rtl/codec_ctrl_regbank.sv
module codec_ctrl_regbank
   import ccr_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h4A,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwrup_strap,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       pwr_down,
   output logic       sidetone_en,
   output logic [1:0] comp_mode,
   output logic       tx_hpf_bypass,
   output logic       rx_hpf_bypass,
   output logic       loopback_en,
   output logic [1:0] tone_res
);

   generate
      if (DEV_ADDR[6:3] == 4'b0000 || DEV_ADDR[6:3] == 4'b1111) begin : g_bad_addr
         $error("target address falls in a reserved range");
      end
   endgenerate

   logic                      scl_s, sda_s, wr_en;
   logic [REG_W-1:0]          wr_data, rd_data;
   logic [IDX_W-1:0]          ptr;
   logic [NUM_REGS*REG_W-1:0] regs_flat;

   ccr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   ccr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   ccr_bus_target #(.DEV_ADDR(DEV_ADDR), .NREGS(NUM_REGS)) u_target (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
      .wr_data(wr_data), .ptr(ptr));

   ccr_regfile #(.NREGS(NUM_REGS), .W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .strap(pwrup_strap), .wr_en(wr_en),
      .idx(ptr), .wr_data(wr_data), .rd_data(rd_data),
      .regs_flat(regs_flat));

   ccr_field_decode #(.NREGS(NUM_REGS)) u_decode (
      .clk(clk), .rst_n(rst_n), .regs_flat(regs_flat),
      .pwr_down(pwr_down), .sidetone_en(sidetone_en),
      .comp_mode(comp_mode), .tx_hpf_bypass(tx_hpf_bypass),
      .rx_hpf_bypass(rx_hpf_bypass), .loopback_en(loopback_en),
      .tone_res(tone_res));

endmodule

// File: tb/codec_ctrl_regbank_bench.sv
module codec_ctrl_regbank_bench;

   localparam logic [6:0] ADDR = 7'h4A;
   localparam int Q = 8;
   localparam int ROWS = 13;

   // {index, data, {pwr_down, sidetone_en, comp_mode, tx_byp, rx_byp, loopback, tone_res}}
   localparam logic [24:0] VEC [ROWS] = '{
      {8'h01, 8'h01, 9'b000100000},
      {8'h01, 8'h02, 9'b001000000},
      {8'h01, 8'h03, 9'b000000000},
      {8'h01, 8'h1C, 9'b000011100},
      {8'h06, 8'h02, 9'b000011110},
      {8'h06, 8'h03, 9'b000011100},
      {8'h00, 8'h09, 9'b010011100},
      {8'h00, 8'h08, 9'b100011100},
      {8'h00, 8'h01, 9'b000011100},
      {8'h06, 8'h01, 9'b000011101},
      {8'h05, 8'hA5, 9'b000011101},
      {8'h02, 8'h4C, 9'b000011101},
      {8'h03, 8'h93, 9'b000011101}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap = 1'b1;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe, pwr_down, sidetone_en, tx_b, rx_b, lpb;
   logic [1:0] comp_mode, tone_res;
   logic sda_line;
   logic [8:0] fields;
   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [7:0] rbuf [8];

   always #4 clk = ~clk;

   assign sda_line = ~(m_low | sda_oe);
   assign fields = {pwr_down, sidetone_en, comp_mode, tx_b, rx_b, lpb, tone_res};

   codec_ctrl_regbank #(.DEV_ADDR(ADDR)) u_codec_ctrl_regbank (
      .clk(clk), .rst_n(rst_n), .pwrup_strap(strap), .scl_i(scl),
      .sda_i(sda_line), .sda_oe(sda_oe), .pwr_down(pwr_down),
      .sidetone_en(sidetone_en), .comp_mode(comp_mode),
      .tx_hpf_bypass(tx_b), .rx_hpf_bypass(rx_b), .loopback_en(lpb),
      .tone_res(tone_res));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; wq();
      scl = 1'b1;   wq();
      m_low = 1'b1; wq();
      scl = 1'b0;   wq();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq();
      scl = 1'b1;   wq();
      m_low = 1'b0; wq();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; wq();
         scl = 1'b1;    wq(2);
         scl = 1'b0;    wq();
      end
      m_low = 1'b0; wq();
      scl = 1'b1;   wq();
      ack = ~sda_line;
      wq();
      scl = 1'b0;   wq();
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wq();
         scl = 1'b1; wq();
         b[i] = sda_line;
         wq();
         scl = 1'b0;
      end
      m_low = give_ack; wq();
      scl = 1'b1;       wq(2);
      scl = 1'b0;       wq();
      m_low = 1'b0;
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [7:0] d, output logic [2:0] acks);
      bus_start();
      wbyte({ADDR, 1'b0}, acks[2]);
      wbyte(idx, acks[1]);
      wbyte(d, acks[0]);
      bus_stop();
   endtask

   task automatic read_burst(input logic [7:0] idx, input int n);
      logic a;
      bus_start();
      wbyte({ADDR, 1'b0}, a);
      wbyte(idx, a);
      bus_start();
      wbyte({ADDR, 1'b1}, a);
      for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
      bus_stop();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [2:0] acks;
      logic a;
      logic [7:0] exp_all [8];

      // reset with strap high
      do_reset();
      chk("R1 sda_oe idle after reset", sda_oe, 1'b0);
      chk("R6 fields after strap-high reset", fields, 9'b000000000);
      read_burst(8'h00, 8);
      exp_all = '{8'h01, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00};
      chk("R6 power reg strap high", rbuf[0], 8'h01);
      for (int i = 1; i < 7; i++) chk("R5 default value", rbuf[i], exp_all[i]);
      chk("R3 read past last index", rbuf[7], 8'h00);

      // table of single writes, readback and decode
      for (int i = 0; i < ROWS; i++) begin
         logic [7:0] ix, dv;
         logic [8:0] fx;
         {ix, dv, fx} = VEC[i];
         write_reg(ix, dv, acks);
         chk("R2 write acks", acks, 3'b111);
         read_burst(ix, 1);
         chk("R2 readback", rbuf[0], dv);
         chk("R7 R8 R9 decoded fields", fields, fx);
      end

      // wrong target address: bytes ignored
      bus_start();
      wbyte({7'h4B, 1'b0}, a);
      chk("R1 foreign address NACK", a, 1'b0);
      wbyte(8'h05, a);
      wbyte(8'h11, a);
      bus_stop();
      read_burst(8'h05, 1);
      chk("R1 foreign write ignored", rbuf[0], 8'hA5);

      // out-of-range index
      write_reg(8'h07, 8'h33, acks);
      chk("R4 index 7 NACK", acks, 3'b100);
      write_reg(8'h86, 8'h33, acks);
      chk("R4 index 0x86 NACK", acks, 3'b100);
      read_burst(8'h00, 7);
      exp_all = '{8'h01, 8'h1C, 8'h4C, 8'h93, 8'h00, 8'hA5, 8'h01, 8'h00};
      for (int i = 0; i < 7; i++) chk("R4 no change after bad index", rbuf[i], exp_all[i]);

      // burst write over the end
      bus_start();
      wbyte({ADDR, 1'b0}, a);
      wbyte(8'h04, a);
      wbyte(8'h5A, a); chk("R3 burst byte 0 ack", a, 1'b1);
      wbyte(8'h3C, a); chk("R3 burst byte 1 ack", a, 1'b1);
      wbyte(8'h02, a); chk("R3 burst byte 2 ack", a, 1'b1);
      wbyte(8'h77, a); chk("R10 overrun byte NACK", a, 1'b0);
      bus_stop();
      read_burst(8'h00, 7);
      exp_all = '{8'h01, 8'h1C, 8'h4C, 8'h93, 8'h5A, 8'h3C, 8'h02, 8'h00};
      for (int i = 0; i < 7; i++) chk("R3 R10 burst result", rbuf[i], exp_all[i]);
      chk("R9 tone step code 10", tone_res, 2'b10);

      // reset with strap low
      strap = 1'b0;
      do_reset();
      chk("R6 strap low powers down", pwr_down, 1'b1);
      chk("R7 sidetone off after reset", sidetone_en, 1'b0);
      read_burst(8'h00, 4);
      chk("R6 power reg strap low", rbuf[0], 8'h00);
      chk("R5 rx gain default", rbuf[3], 8'h20);
      write_reg(8'h00, 8'h09, acks);
      chk("R7 host power-up acks", acks, 3'b111);
      chk("R7 powered up by host", pwr_down, 1'b0);
      chk("R7 sidetone enabled", sidetone_en, 1'b1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule